// File: doc/BRIEF.md
# Reset Cause Capture Register

This block merges the reset requests of a small controller into a single system reset. It also keeps one 8-bit control and status register that software reaches over a simple address/write/read bus. The reset sources are a power-on pulse, a supply-monitor trip, an active-low external reset pin, a watchdog overflow, a missing-clock timeout, a flash access error, an active-low comparator level, and a software force. When any enabled source fires, the block asserts `sys_rst` for a fixed number of clock cycles. It also latches a one-hot record of the source that fired.

The register behaves differently on write and on read. On a write, three bit positions load the enables for the comparator, the clock-loss detector and the supply monitor, and a fourth bit forces a reset. On a read, the same positions return the cause flags of the most recent reset, not the stored enables. Software must therefore never update the register by read-modify-write. Power-on sets only the supply flag. It also loads the default enables: supply monitor on, the other two off. Every other reset leaves the enables as they were.

Top module: `rst_cause_ctl`

## Requirements
- R1: While `por_pulse` is high and for 16 cycles after it falls, `sys_rst` is 1. After that, a read returns 8'h02, `supply_mon_en` is 1 and `clk_mon_en` is 0.
- R2: Any accepted reset request makes `sys_rst` 1 from the next clock edge for exactly HOLD_CYCLES (16) cycles. While `sys_rst` is 1, `bus_rdata` is 0, writes have no effect and new requests are ignored.
- R3: A read at address 8'hEF returns a one-hot cause vector. Bit 0 is the pin, bit 1 power-on or supply monitor, bit 2 clock loss, bit 3 watchdog, bit 4 software force, bit 5 comparator and bit 6 flash error. Bit 7 always reads 0.
- R4: A write to 8'hEF loads the comparator enable from bit 5, the clock-loss enable from bit 2 and the supply enable from bit 1. A read returns the flags, never these enables. Accesses to any other address have no effect and read as 0.
- R5: Writing 8'hEF with bit 4 set forces a reset whose flag is bit 4 (read 8'h10).
- R6: `supply_trip` causes a reset only when the supply enable is 1. `clk_loss` causes a reset only when the clock-loss enable is 1. `cmp_level` low causes a reset only when the comparator enable is 1. A source that is disabled has no effect.
- R7: `rst_pin_n` low, `wdt_ovf` high and `flash_fault` high always cause a reset, with flags 8'h01, 8'h08 and 8'h40.
- R8: When several accepted requests arrive in the same cycle, the one with the lowest flag bit index is recorded.
- R9: A reset from any source other than power-on leaves all three enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| supply_trip | input | 1 | Supply monitor trip |
| rst_pin_n | input | 1 | External reset pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow |
| clk_loss | input | 1 | Missing-clock timeout |
| flash_fault | input | 1 | Flash read/write/erase error |
| cmp_level | input | 1 | Comparator output, reset when low |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |
| sys_rst | output | 1 | System reset, active high |
| supply_mon_en | output | 1 | Enable sent to the supply monitor |
| clk_mon_en | output | 1 | Enable sent to the missing-clock detector |

## Verification
Each source is first fired alone. This separates the seven flag positions and shows that pin, watchdog and flash faults cannot be masked. The gated sources are then fired with their enables off and on, which tells a missing gate from a wrong flag. Writes to other addresses and writes during the hold window show that only idle writes to 8'hEF act. Random mixes of enables and simultaneous requests, checked against a priority function in the bench, confirm that the lowest flag index wins and that enables survive every reset except power-on.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CAUSE_W = 7;
  localparam int B_PIN    = 0;
  localparam int B_SUPPLY = 1;
  localparam int B_CLK    = 2;
  localparam int B_WDT    = 3;
  localparam int B_SW     = 4;
  localparam int B_CMP    = 5;
  localparam int B_FLASH  = 6;

  typedef logic [CAUSE_W-1:0] cause_t;

  typedef struct packed {
    logic cmp;
    logic clk;
    logic supply;
  } enables_t;

  // isolate the lowest set request bit (lowest index has priority)
  function automatic cause_t first_cause(cause_t v);
    return v & (~v + cause_t'(1));
  endfunction

  // place the cause flags on the 8-bit read bus, top bit forced to zero
  function automatic logic [7:0] pack_read(cause_t f);
    return {1'b0, f};
  endfunction
endpackage

// File: rtl/rcc_req_gate.sv
module rcc_req_gate
  import rcc_pkg::*;
(
  input  logic     rst_pin_n,
  input  logic     supply_trip,
  input  logic     clk_loss,
  input  logic     wdt_ovf,
  input  logic     sw_force,
  input  logic     cmp_level,
  input  logic     flash_fault,
  input  enables_t en,
  output cause_t   req,
  output logic     any_req
);
  always_comb begin
    req           = '0;
    req[B_PIN]    = ~rst_pin_n;
    req[B_SUPPLY] = supply_trip & en.supply;
    req[B_CLK]    = clk_loss & en.clk;
    req[B_WDT]    = wdt_ovf;
    req[B_SW]     = sw_force;
    req[B_CMP]    = ~cmp_level & en.cmp;
    req[B_FLASH]  = flash_fault;
  end

  assign any_req = |req;
endmodule

// File: rtl/rcc_hold_timer.sv
module rcc_hold_timer #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic por,
  input  logic start,
  output logic active
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge por) begin
    if (por)                  cnt <= LOAD;
    else if (start && !active) cnt <= LOAD;
    else if (active)           cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // shadow run-length counter for the hold-window check
  logic [CNT_W-1:0] run_len;
  always_ff @(posedge clk or posedge por) begin
    if (por)         run_len <= '0;
    else if (active) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  assert_hold_len_R2: assert property (@(posedge clk) disable iff (por)
    $fell(active) |-> (run_len == LOAD));

  assert_hold_start_R2: assert property (@(posedge clk) disable iff (por)
    (start && !active) |=> active);
endmodule

// File: rtl/rcc_ctrl_reg.sv
module rcc_ctrl_reg
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
  input  logic              clk,
  input  logic              por,
  input  logic              hold_active,
  input  logic              trigger,
  input  cause_t            cause_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output enables_t          en,
  output cause_t            flags,
  output logic              sw_force,
  output logic [7:0]        rdata
);
  logic hit;
  logic wr_ok;

  assign hit      = (bus_addr == REG_ADDR);
  assign wr_ok    = hit && bus_we && !hold_active;
  assign sw_force = wr_ok && bus_wdata[B_SW];

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      en.cmp    <= 1'b0;
      en.clk    <= 1'b0;
      en.supply <= 1'b1;
      flags     <= cause_t'(1) << B_SUPPLY;
    end else begin
      if (wr_ok) begin
        en.cmp    <= bus_wdata[B_CMP];
        en.clk    <= bus_wdata[B_CLK];
        en.supply <= bus_wdata[B_SUPPLY];
      end
      if (trigger) flags <= cause_in;
    end
  end

  assign rdata = (hit && !hold_active) ? pack_read(flags) : 8'h00;

  assert_flag_onehot_R3: assert property (@(posedge clk) disable iff (por)
    trigger |=> ($countones(flags) == 1));

  assert_en_frozen_R2: assert property (@(posedge clk) disable iff (por)
    hold_active |=> $stable(en));

  assert_en_kept_R9: assert property (@(posedge clk) disable iff (por)
    (trigger && !bus_we) |=> $stable(en));
endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
  import rcc_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
  input  logic              clk,
  input  logic              por_pulse,
  input  logic              supply_trip,
  input  logic              rst_pin_n,
  input  logic              wdt_ovf,
  input  logic              clk_loss,
  input  logic              flash_fault,
  input  logic              cmp_level,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sys_rst,
  output logic              supply_mon_en,
  output logic              clk_mon_en
);
  enables_t en;
  cause_t   req;
  cause_t   cause_sel;
  cause_t   flags;
  logic     any_req;
  logic     sw_force;
  logic     trigger;

  rcc_req_gate u_gate (
    .rst_pin_n   (rst_pin_n),
    .supply_trip (supply_trip),
    .clk_loss    (clk_loss),
    .wdt_ovf     (wdt_ovf),
    .sw_force    (sw_force),
    .cmp_level   (cmp_level),
    .flash_fault (flash_fault),
    .en          (en),
    .req         (req),
    .any_req     (any_req)
  );

  assign trigger   = any_req && !sys_rst;
  assign cause_sel = first_cause(req);

  rcc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk    (clk),
    .por    (por_pulse),
    .start  (trigger),
    .active (sys_rst)
  );

  rcc_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk         (clk),
    .por         (por_pulse),
    .hold_active (sys_rst),
    .trigger     (trigger),
    .cause_in    (cause_sel),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .en          (en),
    .flags       (flags),
    .sw_force    (sw_force),
    .rdata       (bus_rdata)
  );

  assign supply_mon_en = en.supply;
  assign clk_mon_en    = en.clk;

  assert_read_blank_R2: assert property (@(posedge clk) disable iff (por_pulse)
    sys_rst |-> (bus_rdata == 8'h00));

  assert_top_bit_R3: assert property (@(posedge clk) disable iff (por_pulse)
    bus_rdata[7] == 1'b0);

  assert_priority_R8: assert property (@(posedge clk) disable iff (por_pulse)
    (trigger && req[B_PIN]) |=> (flags == cause_t'(1)));
endmodule

// File: tb/rst_cause_ctl_test.sv
module rst_cause_ctl_test;
  logic clk = 1'b0;
  logic por_pulse, supply_trip, rst_pin_n, wdt_ovf, clk_loss, flash_fault, cmp_level;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_we, sys_rst, supply_mon_en, clk_mon_en;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model enables: [2]=comparator, [1]=clock loss, [0]=supply
  logic m_cmp, m_clk, m_sup;
  logic [7:0] m_flags;

  always #10 clk = ~clk;

  rst_cause_ctl uut (
    .clk(clk), .por_pulse(por_pulse), .supply_trip(supply_trip), .rst_pin_n(rst_pin_n),
    .wdt_ovf(wdt_ovf), .clk_loss(clk_loss), .flash_fault(flash_fault), .cmp_level(cmp_level),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst(sys_rst), .supply_mon_en(supply_mon_en), .clk_mon_en(clk_mon_en)
  );

  function automatic logic [7:0] pick(logic [6:0] v);
    for (int i = 0; i < 7; i++)
      if (v[i]) return 8'(1) << i;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    supply_trip = 0; rst_pin_n = 1; wdt_ovf = 0; clk_loss = 0;
    flash_fault = 0; cmp_level = 1; bus_we = 0; bus_wdata = 8'h00;
  endtask

  // starts at a negedge right after the reset began; returns high-cycle count
  task automatic hold_len(output int n);
    n = 0;
    while (sys_rst && n < 40) begin
      if (bus_rdata !== 8'h00) begin
        tests++; fails++;
        $display("FAIL R2: got %h expected 00 during hold", bus_rdata);
      end
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(string req, logic [7:0] exp);
    bus_addr = 8'hEF; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic en_chk(string req);
    chk(req, {6'b0, clk_mon_en, supply_mon_en}, {6'b0, m_clk, m_sup});
  endtask

  // one-cycle stimulus: raw = {flash, cmp_low, sw, wdt, clk, sup, pin}
  task automatic fire(logic [6:0] raw, string req);
    logic [6:0] acc;
    int n;
    acc = {raw[6], raw[5] & m_cmp, raw[4], raw[3], raw[2] & m_clk, raw[1] & m_sup, raw[0]};
    rst_pin_n = ~raw[0]; supply_trip = raw[1]; clk_loss = raw[2];
    wdt_ovf = raw[3]; cmp_level = ~raw[5]; flash_fault = raw[6];
    bus_addr = 8'hEF;
    if (raw[4]) begin
      bus_we = 1;
      bus_wdata = {2'b00, m_cmp, 1'b1, 1'b0, m_clk, m_sup, 1'b0};
    end
    @(negedge clk);
    quiet();
    if (acc == 0) begin
      chk({req, " no reset"}, {7'b0, sys_rst}, 8'h00);
      read_chk({req, " flags kept"}, m_flags);
    end else begin
      m_flags = pick(acc);
      hold_len(n);
      chk({req, " R2 hold"}, 8'(n), 8'd16);
      read_chk(req, m_flags);
      en_chk({req, " R9 enables"});
    end
  endtask

  task automatic wr_en(logic c, logic k, logic s);
    bus_addr = 8'hEF; bus_we = 1; bus_wdata = {2'b00, c, 2'b00, k, s, 1'b0};
    @(negedge clk);
    bus_we = 0;
    m_cmp = c; m_clk = k; m_sup = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed));
    quiet();
    bus_addr = 8'hEF;
    por_pulse = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset during por", {7'b0, sys_rst}, 8'h01);
    por_pulse = 0;
    hold_len(n);
    chk("R1 por hold", 8'(n), 8'd16);
    m_cmp = 0; m_clk = 0; m_sup = 1; m_flags = 8'h02;
    read_chk("R1 por flags", 8'h02);
    en_chk("R1 por enables");

    // R4: write enables, read shows flags not enables
    wr_en(1, 1, 0);
    en_chk("R4 enables loaded");
    read_chk("R4 read is flags", 8'h02);

    // R7 unconditional sources
    fire(7'b0000001, "R7 pin");
    fire(7'b0001000, "R7 wdt");
    fire(7'b1000000, "R7 flash");
    // R6 gated sources enabled
    fire(7'b0000100, "R6 clk loss on");
    fire(7'b0100000, "R6 cmp on");
    // R5 software force
    fire(7'b0010000, "R5 sw force");
    read_chk("R5 flag value", 8'h10);
    // R6 disabled sources ignored
    fire(7'b0000010, "R6 supply off");
    wr_en(0, 0, 1);
    fire(7'b0000100, "R6 clk loss off");
    fire(7'b0100000, "R6 cmp off");
    fire(7'b0000010, "R6 supply on");
    read_chk("R6 supply flag", 8'h02);
    // R8 priority pin over watchdog
    fire(7'b0001001, "R8 pin+wdt");
    read_chk("R8 pin wins", 8'h01);

    // R4 other address ignored
    bus_addr = 8'hEE; bus_we = 1; bus_wdata = 8'h14;
    @(negedge clk);
    bus_we = 0;
    chk("R4 other addr no reset", {7'b0, sys_rst}, 8'h00);
    #1 chk("R4 other addr reads 0", bus_rdata, 8'h00);
    en_chk("R4 other addr enables");

    // R2 writes ignored during hold
    wdt_ovf = 1;
    @(negedge clk);
    wdt_ovf = 0;
    bus_addr = 8'hEF; bus_we = 1; bus_wdata = 8'h24;
    @(negedge clk);
    bus_we = 0;
    hold_len(n);
    chk("R2 hold with write", 8'(n), 8'd15);
    m_flags = 8'h08;
    read_chk("R2 flags after hold", 8'h08);
    en_chk("R2 write during hold ignored");

    // random mixes
    for (int it = 0; it < 40; it++) begin
      logic [31:0] r;
      r = $urandom;
      wr_en(r[8], r[9], r[10]);
      fire({r[6], r[5], r[4] & r[7], r[3], r[2], r[1], r[0] & r[11]}, "R8 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule